// File: doc/BRIEF.md
# Reservation Station Bank with Tagged Result Capture

This block is a small pool of reservation slots that sits in front of one group of functional units in an out-of-order core. An issue port writes an operation into the lowest-indexed free slot. For each of its two sources the slot receives either a value or the tag of the slot that will produce it. A source with a zero tag already carries its value, because register contents are copied into the slot when it is written. Later register writes therefore cannot disturb the slot.

A result bus carries a 4-bit producer tag and 64 bits of data. Every slot compares the bus tag against both of its pending source tags in every cycle. On a match the slot takes the data and clears that tag, so any number of waiting slots can wake on one broadcast. A slot whose two source tags are both zero is offered to the execution unit on the select outputs. The lowest-indexed such slot wins, and it is then marked as executing so that it is never offered again. When the bus later carries the slot's own tag, the slot becomes free.

Each slot has a fixed tag equal to `BASE_TAG` plus its index. Tag 0 is reserved to mean "no producer".

Top module: `rs_bank`

## Requirements
- R1: After reset every slot is free: `iss_ready` is 1, `iss_tag` is `BASE_TAG` (1 by default) and `sel_valid` is 0.
- R2: When `iss_valid` and `iss_ready` are both 1 at a clock edge, the operation is written into the lowest-indexed free slot. Before that edge, `iss_tag` shows that slot's tag, which is `BASE_TAG` + index.
- R3: A source whose issue tag is 0 takes its value from the issue port. That value is kept unchanged until the slot is dispatched.
- R4: A source with a nonzero tag waits. When `bus_valid` is 1 and `bus_tag` equals that tag, the slot loads `bus_data` into the source. The slot can be selected from the next cycle on.
- R5: If the bus shows a source's tag in the same cycle that the source is issued, `bus_data` is written into the slot directly and the source counts as ready.
- R6: One broadcast wakes every waiting source that holds the matching tag, in all slots at once.
- R7: `sel_valid` is 1 while some busy, non-executing slot has both sources ready. `sel_op`, `sel_src1`, `sel_src2` and `sel_tag` then come from the lowest-indexed such slot. That slot is executing from the next cycle on and is offered only once.
- R8: A valid broadcast of a busy slot's own tag frees that slot at the clock edge.
- R9: With every slot busy, `iss_ready` is 0 and `iss_valid` writes nothing.
- R10: While `bus_valid` is 0, the bus tag and data change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 6 | Operation code to store |
| iss_src1_tag | input | 4 | Producer tag of source 1, 0 = value given |
| iss_src1_val | input | 64 | Value of source 1 when its tag is 0 |
| iss_src2_tag | input | 4 | Producer tag of source 2, 0 = value given |
| iss_src2_val | input | 64 | Value of source 2 when its tag is 0 |
| iss_ready | output | 1 | A free slot exists |
| iss_tag | output | 4 | Tag of the slot the next issue will take |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | 4 | Tag of the producing slot |
| bus_data | input | 64 | Result value |
| sel_valid | output | 1 | A slot is dispatched this cycle |
| sel_op | output | 6 | Operation code of the dispatched slot |
| sel_src1 | output | 64 | Source 1 value of the dispatched slot |
| sel_src2 | output | 64 | Source 2 value of the dispatched slot |
| sel_tag | output | 4 | Tag of the dispatched slot |

## Verification
The main function is tried with four input patterns. The first is an operation issued with both values present, which shows the basic write, dispatch and free path. The second is a group of slots waiting on one external tag; it checks that a single broadcast wakes several slots and that the priority order holds when they become ready together. A broadcast with `bus_valid` low is sent first, to show that only qualified broadcasts are captured. The third is an issue that coincides with the broadcast of its own source tag, which checks the bypass at issue. The fourth is an issue attempt into a full bank followed by a free and a reissue, which shows the stall and the reuse of a released slot.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int RS_DATA_W = 64;
    localparam int RS_TAG_W  = 4;
    localparam int RS_OP_W   = 6;

    typedef logic [RS_DATA_W-1:0] rs_data_t;
    typedef logic [RS_TAG_W-1:0]  rs_tag_t;
    typedef logic [RS_OP_W-1:0]   rs_op_t;

    typedef struct packed {
        logic     busy;
        logic     exec;
        rs_op_t   op;
        rs_data_t v1;
        rs_data_t v2;
        rs_tag_t  q1;
        rs_tag_t  q2;
    } rs_slot_t;

    typedef struct packed {
        rs_tag_t  q;
        rs_data_t v;
    } rs_src_t;

    // Resolve one source at issue: value given, bypass from bus, or wait on tag.
    function automatic rs_src_t resolve_src(input rs_tag_t tag, input rs_data_t val,
                                            input logic bv, input rs_tag_t bt,
                                            input rs_data_t bd);
        rs_src_t s;
        if (tag == '0) begin
            s.q = '0;
            s.v = val;
        end else if (bv && bt == tag) begin
            s.q = '0;
            s.v = bd;
        end else begin
            s.q = tag;
            s.v = '0;
        end
        return s;
    endfunction
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    always_comb begin
        found  = 1'b0;
        onehot = '0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found  = 1'b1;
                onehot = '0;
                onehot[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter rs_tag_t MY_TAG = 4'd1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  rs_slot_t wr_slot,
    input  logic     bus_valid,
    input  rs_tag_t  bus_tag,
    input  rs_data_t bus_data,
    input  logic     grant,
    output rs_slot_t slot,
    output logic     ready
);
    logic hit1, hit2, own_done;

    assign hit1     = bus_valid && slot.q1 != '0 && bus_tag == slot.q1;
    assign hit2     = bus_valid && slot.q2 != '0 && bus_tag == slot.q2;
    assign own_done = bus_valid && bus_tag == MY_TAG;
    assign ready    = slot.busy && !slot.exec && slot.q1 == '0 && slot.q2 == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (wr_en) begin
            slot <= wr_slot;
        end else if (slot.busy) begin
            if (own_done) begin
                slot.busy <= 1'b0;
                slot.exec <= 1'b0;
            end else begin
                if (hit1) begin
                    slot.v1 <= bus_data;
                    slot.q1 <= '0;
                end
                if (hit2) begin
                    slot.v2 <= bus_data;
                    slot.q2 <= '0;
                end
                if (grant) slot.exec <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_bank.sv
module rs_bank
    import rs_pkg::*;
#(
    parameter int      NUM_ENT  = 4,
    parameter rs_tag_t BASE_TAG = 4'd1,
    localparam int     IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [RS_OP_W-1:0]   iss_op,
    input  logic [RS_TAG_W-1:0]  iss_src1_tag,
    input  logic [RS_DATA_W-1:0] iss_src1_val,
    input  logic [RS_TAG_W-1:0]  iss_src2_tag,
    input  logic [RS_DATA_W-1:0] iss_src2_val,
    output logic                 iss_ready,
    output logic [RS_TAG_W-1:0]  iss_tag,
    input  logic                 bus_valid,
    input  logic [RS_TAG_W-1:0]  bus_tag,
    input  logic [RS_DATA_W-1:0] bus_data,
    output logic                 sel_valid,
    output logic [RS_OP_W-1:0]   sel_op,
    output logic [RS_DATA_W-1:0] sel_src1,
    output logic [RS_DATA_W-1:0] sel_src2,
    output logic [RS_TAG_W-1:0]  sel_tag
);
    rs_slot_t             slots [NUM_ENT];
    logic [NUM_ENT-1:0]   busy_vec, ready_vec, free_oh, grant_oh;
    logic [IW-1:0]        free_idx, sel_idx;
    rs_slot_t             new_slot;
    rs_src_t              s1, s2;

    always_comb begin
        s1 = resolve_src(iss_src1_tag, iss_src1_val, bus_valid, bus_tag, bus_data);
        s2 = resolve_src(iss_src2_tag, iss_src2_val, bus_valid, bus_tag, bus_data);
        new_slot      = '0;
        new_slot.busy = 1'b1;
        new_slot.op   = iss_op;
        new_slot.v1   = s1.v;
        new_slot.q1   = s1.q;
        new_slot.v2   = s2.v;
        new_slot.q2   = s2.q;
    end

    rs_prio_pick #(.N(NUM_ENT)) u_free_pick (
        .req(~busy_vec), .found(iss_ready), .onehot(free_oh), .idx(free_idx)
    );
    rs_prio_pick #(.N(NUM_ENT)) u_sel_pick (
        .req(ready_vec), .found(sel_valid), .onehot(grant_oh), .idx(sel_idx)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
        rs_slot #(.MY_TAG(BASE_TAG + RS_TAG_W'(i))) u_slot (
            .clk(clk), .rst(rst),
            .wr_en(iss_valid && free_oh[i]),
            .wr_slot(new_slot),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
            .grant(grant_oh[i]),
            .slot(slots[i]), .ready(ready_vec[i])
        );
        assign busy_vec[i] = slots[i].busy;
    end

    assign iss_tag  = BASE_TAG + RS_TAG_W'(free_idx);
    assign sel_tag  = BASE_TAG + RS_TAG_W'(sel_idx);
    assign sel_op   = slots[sel_idx].op;
    assign sel_src1 = slots[sel_idx].v1;
    assign sel_src2 = slots[sel_idx].v2;
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk
    import rs_pkg::*;
#(
    parameter int      NUM_ENT  = 4,
    parameter rs_tag_t BASE_TAG = 4'd1
) (
    input logic                clk,
    input logic                rst,
    input logic                iss_valid,
    input logic                iss_ready,
    input logic                bus_valid,
    input logic [RS_TAG_W-1:0] bus_tag,
    input logic                sel_valid,
    input logic [RS_TAG_W-1:0] sel_tag,
    input logic [NUM_ENT-1:0]  busy_vec,
    input logic [NUM_ENT-1:0]  free_oh,
    input logic [NUM_ENT-1:0]  grant_oh
);
    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_oh));

    // R7
    no_regrant_chk: assert property (@(posedge clk) disable iff (rst)
        sel_valid && !(bus_valid && bus_tag == sel_tag)
        |=> !(sel_valid && sel_tag == $past(sel_tag)));

    // R2
    issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid && iss_ready |=> (busy_vec & $past(free_oh)) != '0);

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !iss_ready |-> busy_vec == '1);

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_free
        // R8
        own_free_chk: assert property (@(posedge clk) disable iff (rst)
            bus_valid && busy_vec[k] && bus_tag == BASE_TAG + RS_TAG_W'(k)
            |=> !busy_vec[k]);
    end
endmodule

bind rs_bank rs_bank_chk #(.NUM_ENT(NUM_ENT), .BASE_TAG(BASE_TAG)) u_chk (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .sel_valid(sel_valid),
    .sel_tag(sel_tag), .busy_vec(busy_vec), .free_oh(free_oh), .grant_oh(grant_oh)
);

// File: tb/tb_rs_bank.sv
module tb_rs_bank;
    logic        clk = 0, rst = 1;
    logic        iss_valid = 0;
    logic [5:0]  iss_op = 0;
    logic [3:0]  iss_src1_tag = 0, iss_src2_tag = 0;
    logic [63:0] iss_src1_val = 0, iss_src2_val = 0;
    logic        iss_ready;
    logic [3:0]  iss_tag;
    logic        bus_valid = 0;
    logic [3:0]  bus_tag = 0;
    logic [63:0] bus_data = 0;
    logic        sel_valid;
    logic [5:0]  sel_op;
    logic [63:0] sel_src1, sel_src2;
    logic [3:0]  sel_tag;

    typedef struct packed {
        logic [5:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [3:0]  tag;
    } disp_t;

    disp_t expq[$];
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    rs_bank dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        iss_valid = 0;
        bus_valid = 0;
    endtask

    task automatic set_issue(input logic [5:0] op, input logic [3:0] t1,
                             input logic [63:0] v1, input logic [3:0] t2,
                             input logic [63:0] v2);
        iss_valid = 1; iss_op = op;
        iss_src1_tag = t1; iss_src1_val = v1;
        iss_src2_tag = t2; iss_src2_val = v2;
    endtask

    task automatic set_bus(input logic v, input logic [3:0] t, input logic [63:0] d);
        bus_valid = v; bus_tag = t; bus_data = d;
    endtask

    task automatic expect_disp(input logic [5:0] op, input logic [63:0] a,
                               input logic [63:0] b, input logic [3:0] tag);
        disp_t e;
        e.op = op; e.a = a; e.b = b; e.tag = tag;
        expq.push_back(e);
    endtask

    // Monitor: every dispatch must match the next predicted one (R3..R7)
    always @(negedge clk) begin
        if (!rst && sel_valid) begin
            if (expq.size() == 0) begin
                check(0, "R7", "unexpected dispatch tag", sel_tag, 0);
            end else begin
                disp_t e;
                e = expq.pop_front();
                check(sel_op == e.op, "R7", "dispatch op", sel_op, e.op);
                check(sel_src1 == e.a, "R4", "dispatch src1", sel_src1, e.a);
                check(sel_src2 == e.b, "R3", "dispatch src2", sel_src2, e.b);
                check(sel_tag == e.tag, "R7", "dispatch tag", sel_tag, e.tag);
            end
        end
    end

    initial begin
        #100000;
        check(0, "R1", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        rst = 0;
        #1;
        // R1 reset state
        check(iss_ready == 1, "R1", "iss_ready after reset", iss_ready, 1);
        check(iss_tag == 1, "R1", "iss_tag after reset", iss_tag, 1);
        check(sel_valid == 0, "R1", "sel_valid after reset", sel_valid, 0);

        // R2 / R3: ready operands, dispatch next cycle, then free via own tag (R8)
        expect_disp(6'd5, 64'd10, 64'd20, 4'd1);
        set_issue(6'd5, 0, 64'd10, 0, 64'd20);
        step();
        check(iss_tag == 2, "R2", "next free tag after first issue", iss_tag, 2);
        step();
        set_bus(1, 4'd1, 64'hdead);
        step();
        check(iss_tag == 1, "R8", "slot 1 free after own broadcast", iss_tag, 1);

        // Three waiting slots
        set_issue(6'd7, 4'd9, 0, 0, 64'd3);       step(); // tag 1
        set_issue(6'd8, 4'd9, 0, 4'd9, 0);        step(); // tag 2
        set_issue(6'd9, 0, 64'd4, 4'd12, 0);      step(); // tag 3
        check(iss_tag == 4, "R2", "lowest free slot is tag 4", iss_tag, 4);
        // R10: invalid broadcast ignored (monitor fails on any dispatch)
        set_bus(0, 4'd9, 64'd55); step();
        step();
        check(sel_valid == 0, "R10", "no wake from invalid bus", sel_valid, 0);

        // R6: one broadcast wakes slots 1 and 2; R7 lowest index first
        expect_disp(6'd7, 64'd100, 64'd3, 4'd1);
        expect_disp(6'd8, 64'd100, 64'd100, 4'd2);
        set_bus(1, 4'd9, 64'd100); step();
        step(); step();

        // R5: issue with bypass while slot 3 captures the same broadcast
        expect_disp(6'd9, 64'd4, 64'd77, 4'd3);
        expect_disp(6'd10, 64'd77, 64'd6, 4'd4);
        set_issue(6'd10, 4'd12, 0, 0, 64'd6);
        set_bus(1, 4'd12, 64'd77);
        step();
        step(); step();

        // R9: full bank
        check(iss_ready == 0, "R9", "iss_ready when full", iss_ready, 0);
        set_issue(6'd11, 0, 64'd1, 0, 64'd1); step();
        step();
        set_bus(1, 4'd2, 64'hbeef); step();
        check(iss_ready == 1, "R8", "iss_ready after free", iss_ready, 1);
        check(iss_tag == 2, "R9", "freed slot reused, stalled issue dropped", iss_tag, 2);
        expect_disp(6'd12, 64'd1, 64'd2, 4'd2);
        set_issue(6'd12, 0, 64'd1, 0, 64'd2); step();
        step(); step();
        check(expq.size() == 0, "R7", "pending expected dispatches", expq.size(), 0);
        check(sel_valid == 0, "R7", "no repeat dispatch", sel_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule